// File: doc/BRIEF.md
# Double-Buffered Luma Frame Capture and Block-Search Address Controller

This block sits between a parallel camera port and the pixel stores of a block-matching motion estimator. While a frame is being delivered it keeps only the luma byte of each chroma/luma byte pair. It writes those bytes in raster order into one of two frame stores. Each store is split into single-port SRAM banks of `2**BANK_AW` words. The upper address bits choose the bank and the lower bits address a word inside it. The two stores trade places at the start of every frame, so the store filled by the last frame always holds the reference image for the next one.

When the frame-valid input drops, the stores are free for reading. The controller then walks a full search. For every block of the image it visits each candidate displacement in a square window of plus or minus `SRCH` pixels. At each displacement it reads every pixel of the block from the older store and the matching displaced pixel from the newer store. Displaced pixels that fall outside the image are not fetched; they are flagged as zero instead. A second pipeline stage supplies the read-data steering (bank numbers and the zero flag) aligned with the synchronous SRAM output. It also supplies a strobe at the end of each block search and a regenerated frame/line-valid pair for the downstream vector stream.

Top module: `cap_pingpong_ctrl`

## Requirements
- R1: Each store has one active-low enable per bank and a shared active-low write enable. Enable low with write enable low is a write; enable low with write enable high is a read; all enables high is standby. Address bits [AW-1:BANK_AW] give the number of the single enabled bank, and the full address appears on that store's address port.
- R2: A byte is written only when it was sampled with frame-valid and line-valid both high, and only if it is the second byte of a pair. The first byte after line-valid rises is discarded. The write appears on the outputs one clock after the byte is sampled, carrying that byte as write data.
- R3: The write address is 0 for the first luma byte of every frame and rises by one per stored byte. It holds across line-valid low gaps. The byte pairing restarts whenever line-valid goes low, so a one-byte line-valid pulse stores nothing.
- R4: The first frame after reset is written to store 0, and the stores alternate on every frame-valid rising edge. The store not being written stays in standby throughout the frame.
- R5: Reads begin only after frame-valid falls: the first read is on the outputs two clocks after the first low sample. A new frame-valid rise stops the walk at once. With a fall at sample edge 1 and a rise sampled at edge k+1, exactly k-1 reads are issued.
- R6: The read walk is ordered block row, block column, vertical offset, horizontal offset, pixel row, pixel column, with offsets running from -SRCH to +SRCH. Reference reads address (row*IMG_W + col) in the store written before the latest one. Search reads address the displaced pixel in the latest store.
- R7: A search pixel outside the image leaves every enable of the search store high for that read, and raises `srch_zero` one clock later.
- R8: One clock after each read, `rd_vld` is high and `ref_bank_sel` and `srch_bank_sel` hold the bank numbers used by that read. Otherwise `rd_vld` is low.
- R9: `pix_stb` pulses together with the `rd_vld` of the last read of each block's search, once per block, and at no other time.
- R10: `fv_out` equals the inverse of frame-valid as sampled on the previous clock, and `lv_out` always equals `fv_out`.
- R11: During reset all bank enables and write enables are high, and `rd_vld`, `pix_stb` and `fv_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| fv_in | input | 1 | Camera frame-valid |
| lv_in | input | 1 | Camera line-valid |
| pix_in | input | 8 | Camera data byte |
| st0_ce_n | output | NBANK | Store 0 per-bank enables, active low |
| st0_we_n | output | 1 | Store 0 write enable, active low |
| st0_addr | output | AW | Store 0 frame address |
| st1_ce_n | output | NBANK | Store 1 per-bank enables, active low |
| st1_we_n | output | 1 | Store 1 write enable, active low |
| st1_addr | output | AW | Store 1 frame address |
| wdata | output | 8 | Luma byte being written |
| ref_bank_sel | output | AW-BANK_AW | Bank whose data is the reference pixel |
| srch_bank_sel | output | AW-BANK_AW | Bank whose data is the search pixel |
| srch_zero | output | 1 | Search pixel is outside the image, use zero |
| rd_vld | output | 1 | Read data steering valid this clock |
| fv_out | output | 1 | Regenerated frame-valid for the vector stream |
| lv_out | output | 1 | Regenerated line-valid for the vector stream |
| pix_stb | output | 1 | End-of-block-search strobe |

## Verification
A write is due on the outputs one clock after its luma byte is sampled. A read address is due one clock after the read counters hold it, so the first read lands two clocks after the first low frame-valid sample. Its steering and block strobe follow one clock after that, and `fv_out` lags the input by one clock. The driver places every expected write and read on a queue before its sampling edge. The monitor samples at the falling edge and pops one entry each time a write or read is visible on the bank pins. It checks the steering outputs at the next falling edge against the entry popped one clock earlier. The aborted walk is judged by the exact number of reads that reached the pins, which pins down both the start and the stop latency.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic {
        PH_CHROMA = 1'b0,
        PH_LUMA   = 1'b1
    } byte_phase_e;

    typedef struct packed {
        logic vld;
        logic zero;
        logic last;
    } rd_tag_t;

    function automatic int cntw(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl #(
    parameter int PIX = 101376,
    parameter int AW  = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fv_in,
    input  logic          lv_in,
    output logic          fv_fall,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic          wr_store,
    output logic          cur_store
);
    import cap_pkg::*;

    localparam int CW = $clog2(PIX + 1);

    logic            fv_q;
    logic            wsel;
    byte_phase_e     phase, phase_eff;
    logic [CW-1:0]   wcnt, base;
    logic            fv_rise;

    assign fv_rise   = fv_in && !fv_q;
    assign fv_fall   = !fv_in && fv_q;
    assign phase_eff = fv_rise ? PH_CHROMA : phase;
    assign base      = fv_rise ? '0 : wcnt;
    assign wr_fire   = fv_in && lv_in && (phase_eff == PH_LUMA) && (base < CW'(PIX));
    assign wr_addr   = base[AW-1:0];
    assign wr_store  = fv_rise ? !wsel : wsel;
    assign cur_store = wsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            fv_q  <= 1'b0;
            wsel  <= 1'b1;
            phase <= PH_CHROMA;
            wcnt  <= '0;
        end else begin
            fv_q <= fv_in;
            if (fv_rise) wsel <= !wsel;
            if (fv_in && lv_in)
                phase <= (phase_eff == PH_LUMA) ? PH_CHROMA : PH_LUMA;
            else
                phase <= PH_CHROMA;
            wcnt <= wr_fire ? base + 1'b1 : base;
        end
    end

    // R4
    swap_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (wsel != $past(wsel)) |-> $past(fv_in && !fv_q));

    // R3
    wcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wcnt <= CW'(PIX));

endmodule

// File: rtl/cap_rd_agu.sv
module cap_rd_agu #(
    parameter int IMG_W = 352,
    parameter int IMG_H = 288,
    parameter int BLK   = 16,
    parameter int SRCH  = 7,
    parameter int AW    = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    output logic          act,
    output logic [AW-1:0] ref_addr,
    output logic [AW-1:0] srch_addr,
    output logic          srch_in,
    output logic          blk_last
);
    import cap_pkg::*;

    localparam int NBX = IMG_W / BLK;
    localparam int NBY = IMG_H / BLK;
    localparam int NSP = 2 * SRCH + 1;
    localparam int BXW = cntw(NBX);
    localparam int BYW = cntw(NBY);
    localparam int SPW = cntw(NSP);
    localparam int PW  = cntw(BLK);

    logic [BXW-1:0] bx;
    logic [BYW-1:0] by;
    logic [SPW-1:0] dx, dy;
    logic [PW-1:0]  pi, pj;
    logic j_end, i_end, dx_end, dy_end, bx_end, by_end;

    assign j_end  = (pj == PW'(BLK - 1));
    assign i_end  = (pi == PW'(BLK - 1));
    assign dx_end = (dx == SPW'(NSP - 1));
    assign dy_end = (dy == SPW'(NSP - 1));
    assign bx_end = (bx == BXW'(NBX - 1));
    assign by_end = (by == BYW'(NBY - 1));
    assign blk_last = act && j_end && i_end && dx_end && dy_end;

    always_comb begin
        int rr, rc, sr, sc;
        rr = int'(by) * BLK + int'(pi);
        rc = int'(bx) * BLK + int'(pj);
        sr = rr + int'(dy) - SRCH;
        sc = rc + int'(dx) - SRCH;
        srch_in   = (sr >= 0) && (sr < IMG_H) && (sc >= 0) && (sc < IMG_W);
        ref_addr  = AW'(rr * IMG_W + rc);
        srch_addr = srch_in ? AW'(sr * IMG_W + sc) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            act <= 1'b0;
            bx <= '0; by <= '0; dx <= '0; dy <= '0; pi <= '0; pj <= '0;
        end else if (start) begin
            act <= 1'b1;
            bx <= '0; by <= '0; dx <= '0; dy <= '0; pi <= '0; pj <= '0;
        end else if (act) begin
            pj <= j_end ? '0 : pj + 1'b1;
            if (j_end)
                pi <= i_end ? '0 : pi + 1'b1;
            if (j_end && i_end)
                dx <= dx_end ? '0 : dx + 1'b1;
            if (j_end && i_end && dx_end)
                dy <= dy_end ? '0 : dy + 1'b1;
            if (blk_last)
                bx <= bx_end ? '0 : bx + 1'b1;
            if (blk_last && bx_end)
                by <= by_end ? '0 : by + 1'b1;
            if (blk_last && bx_end && by_end)
                act <= 1'b0;
        end
    end

    // R6
    ref_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        act |-> (int'(ref_addr) < IMG_W * IMG_H));

endmodule

// File: rtl/cap_bank_dec.sv
module cap_bank_dec #(
    parameter int AW      = 17,
    parameter int BANK_AW = 14,
    parameter int NBANK   = 7
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [NBANK-1:0] ce_n
);
    localparam int SBW = AW - BANK_AW;

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        assign ce_n[k] = !(en && (addr[AW-1:BANK_AW] == SBW'(k)));
    end

endmodule

// File: rtl/cap_pingpong_ctrl.sv
module cap_pingpong_ctrl #(
    parameter  int IMG_W   = 352,
    parameter  int IMG_H   = 288,
    parameter  int BLK     = 16,
    parameter  int SRCH    = 7,
    parameter  int BANK_AW = 14,
    localparam int PIX     = IMG_W * IMG_H,
    localparam int AW      = $clog2(PIX),
    localparam int NBANK   = cap_pkg::ceil_div(PIX, 2 ** BANK_AW),
    localparam int SBW     = AW - BANK_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fv_in,
    input  logic             lv_in,
    input  logic [7:0]       pix_in,
    output logic [NBANK-1:0] st0_ce_n,
    output logic             st0_we_n,
    output logic [AW-1:0]    st0_addr,
    output logic [NBANK-1:0] st1_ce_n,
    output logic             st1_we_n,
    output logic [AW-1:0]    st1_addr,
    output logic [7:0]       wdata,
    output logic [SBW-1:0]   ref_bank_sel,
    output logic [SBW-1:0]   srch_bank_sel,
    output logic             srch_zero,
    output logic             rd_vld,
    output logic             fv_out,
    output logic             lv_out,
    output logic             pix_stb
);
    import cap_pkg::*;

    logic          fv_fall, wr_fire, wr_store, cur_store;
    logic [AW-1:0] wr_addr;
    logic          agu_act, srch_in, blk_last;
    logic [AW-1:0] ref_addr, srch_addr;

    logic [1:0]             en_q, we_n_q;
    logic [1:0][AW-1:0]     addr_q;
    logic [1:0][NBANK-1:0]  ce_n_v;
    logic [7:0]             wdata_q;
    rd_tag_t                s1_tag;
    logic [SBW-1:0]         s1_ref_bank, s1_srch_bank;

    cap_wr_ctrl #(.PIX(PIX), .AW(AW)) u_wr (
        .clk(clk), .rst(rst), .fv_in(fv_in), .lv_in(lv_in),
        .fv_fall(fv_fall), .wr_fire(wr_fire), .wr_addr(wr_addr),
        .wr_store(wr_store), .cur_store(cur_store)
    );

    cap_rd_agu #(.IMG_W(IMG_W), .IMG_H(IMG_H), .BLK(BLK), .SRCH(SRCH), .AW(AW)) u_agu (
        .clk(clk), .rst(rst), .start(fv_fall), .stop(fv_in),
        .act(agu_act), .ref_addr(ref_addr), .srch_addr(srch_addr),
        .srch_in(srch_in), .blk_last(blk_last)
    );

    for (genvar s = 0; s < 2; s++) begin : g_store
        cap_bank_dec #(.AW(AW), .BANK_AW(BANK_AW), .NBANK(NBANK)) u_dec (
            .en(en_q[s]), .addr(addr_q[s]), .ce_n(ce_n_v[s])
        );
    end

    // Stage 1: bank pins
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q         <= '0;
            we_n_q       <= '1;
            addr_q       <= '0;
            wdata_q      <= '0;
            s1_tag       <= '0;
            s1_ref_bank  <= '0;
            s1_srch_bank <= '0;
        end else begin
            en_q   <= '0;
            we_n_q <= '1;
            addr_q <= '0;
            s1_tag <= '0;
            if (wr_fire) begin
                en_q[wr_store]   <= 1'b1;
                we_n_q[wr_store] <= 1'b0;
                addr_q[wr_store] <= wr_addr;
                wdata_q          <= pix_in;
            end else if (agu_act && !fv_in) begin
                en_q[!cur_store]   <= 1'b1;
                addr_q[!cur_store] <= ref_addr;
                en_q[cur_store]    <= srch_in;
                addr_q[cur_store]  <= srch_addr;
                s1_tag       <= '{vld: 1'b1, zero: !srch_in, last: blk_last};
                s1_ref_bank  <= ref_addr[AW-1:BANK_AW];
                s1_srch_bank <= srch_addr[AW-1:BANK_AW];
            end
        end
    end

    // Stage 2: read steering aligned with synchronous SRAM data
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_bank_sel  <= '0;
            srch_bank_sel <= '0;
            srch_zero     <= 1'b0;
            rd_vld        <= 1'b0;
            pix_stb       <= 1'b0;
            fv_out        <= 1'b0;
        end else begin
            ref_bank_sel  <= s1_ref_bank;
            srch_bank_sel <= s1_srch_bank;
            srch_zero     <= s1_tag.vld && s1_tag.zero;
            rd_vld        <= s1_tag.vld;
            pix_stb       <= s1_tag.vld && s1_tag.last;
            fv_out        <= !fv_in;
        end
    end

    assign lv_out   = fv_out;
    assign st0_ce_n = ce_n_v[0];
    assign st1_ce_n = ce_n_v[1];
    assign st0_we_n = we_n_q[0];
    assign st1_we_n = we_n_q[1];
    assign st0_addr = addr_q[0];
    assign st1_addr = addr_q[1];
    assign wdata    = wdata_q;

    // R1
    bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~st0_ce_n) && $onehot0(~st1_ce_n));

    // R2
    write_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!st0_we_n || !st1_we_n) |-> $past(fv_in && lv_in));

    // R5
    read_idle_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (st0_we_n && st1_we_n && ((~st0_ce_n) != '0 || (~st1_ce_n) != '0))
        |-> !$past(fv_in));

    // R8
    steer_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> $past(st0_we_n && st1_we_n && ((~st0_ce_n) != '0 || (~st1_ce_n) != '0)));

endmodule

// File: tb/cap_pingpong_ctrl_bench.sv
module cap_pingpong_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 8, H = 8, B = 4, R = 1, BA = 3;
    localparam int PIX = W * H;
    localparam int AW = $clog2(PIX);
    localparam int NBANK = (PIX + (1 << BA) - 1) >> BA;
    localparam int SBW = AW - BA;
    localparam int NSP = 2 * R + 1;
    localparam int NBLK = (W / B) * (H / B);
    localparam int NRD = NBLK * NSP * NSP * B * B;

    logic clk = 1'b0, rst = 1'b1, fv_in = 1'b0, lv_in = 1'b0;
    logic [7:0] pix_in = 8'h00;
    logic [NBANK-1:0] st0_ce_n, st1_ce_n;
    logic st0_we_n, st1_we_n, srch_zero, rd_vld, fv_out, lv_out, pix_stb;
    logic [AW-1:0] st0_addr, st1_addr;
    logic [7:0] wdata;
    logic [SBW-1:0] ref_bank_sel, srch_bank_sel;

    always #2.5 clk = ~clk;

    cap_pingpong_ctrl #(.IMG_W(W), .IMG_H(H), .BLK(B), .SRCH(R), .BANK_AW(BA)) u_cap_pingpong_ctrl (
        .clk(clk), .rst(rst), .fv_in(fv_in), .lv_in(lv_in), .pix_in(pix_in),
        .st0_ce_n(st0_ce_n), .st0_we_n(st0_we_n), .st0_addr(st0_addr),
        .st1_ce_n(st1_ce_n), .st1_we_n(st1_we_n), .st1_addr(st1_addr),
        .wdata(wdata), .ref_bank_sel(ref_bank_sel), .srch_bank_sel(srch_bank_sel),
        .srch_zero(srch_zero), .rd_vld(rd_vld), .fv_out(fv_out), .lv_out(lv_out),
        .pix_stb(pix_stb)
    );

    typedef struct packed { logic st; logic [AW-1:0] a; logic [7:0] d; } wexp_t;
    typedef struct packed { logic rs; logic [AW-1:0] ra; logic zero; logic [AW-1:0] sa; logic last; } rexp_t;

    wexp_t wq[$];
    rexp_t rq[$];
    int nchk = 0, nerr = 0, rd_pops = 0, stb_cnt = 0;
    logic live = 1'b0, fv_smp = 1'b0, prev_rd = 1'b0, done = 1'b0;
    rexp_t prev_e;
    logic [1:0][NBANK-1:0] ce_v;
    logic [1:0] we_v;
    logic [1:0][AW-1:0] ad_v;

    assign ce_v[0] = st0_ce_n; assign ce_v[1] = st1_ce_n;
    assign we_v = {st1_we_n, st0_we_n};
    assign ad_v[0] = st0_addr; assign ad_v[1] = st1_addr;

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NBANK-1:0] ce_for(input logic [AW-1:0] a);
        return ~(NBANK'(1) << a[AW-1:BA]);
    endfunction

    always @(posedge clk) begin
        fv_smp <= fv_in;
        live   <= !rst;
    end

    // Monitor: pops the scoreboard when a write or read shows on the bank pins
    always @(negedge clk) begin
        if (live && !done) begin
            chk(fv_out == !fv_smp, "R10", "fv_out", fv_out, !fv_smp);
            chk(lv_out == fv_out, "R10", "lv_out", lv_out, fv_out);
            if (prev_rd) begin
                chk(rd_vld == 1'b1, "R8", "rd_vld", rd_vld, 1);
                chk(ref_bank_sel == prev_e.ra[AW-1:BA], "R8", "ref_bank_sel", ref_bank_sel, prev_e.ra[AW-1:BA]);
                chk(srch_zero == prev_e.zero, "R7", "srch_zero", srch_zero, prev_e.zero);
                if (!prev_e.zero)
                    chk(srch_bank_sel == prev_e.sa[AW-1:BA], "R8", "srch_bank_sel", srch_bank_sel, prev_e.sa[AW-1:BA]);
                chk(pix_stb == prev_e.last, "R9", "pix_stb", pix_stb, prev_e.last);
            end else begin
                chk(rd_vld == 1'b0, "R8", "rd_vld idle", rd_vld, 0);
                chk(pix_stb == 1'b0, "R9", "pix_stb idle", pix_stb, 0);
            end
            if (pix_stb) stb_cnt++;
            prev_rd = 1'b0;
            if (we_v != 2'b11) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected write", we_v, 3);
                end else begin
                    wexp_t e;
                    e = wq.pop_front();
                    chk(we_v[e.st] == 1'b0, "R4", "write store", we_v, e.st);
                    chk(ce_v[e.st] == ce_for(e.a), "R1", "write bank enables", ce_v[e.st], ce_for(e.a));
                    chk(ad_v[e.st] == e.a, "R3", "write address", ad_v[e.st], e.a);
                    chk(wdata == e.d, "R2", "write data", wdata, e.d);
                    chk(ce_v[!e.st] == '1 && we_v[!e.st], "R4", "idle store standby", ce_v[!e.st], '1);
                end
            end else if (ce_v[0] != '1 || ce_v[1] != '1) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R5", "unexpected read", ce_v, 0);
                end else begin
                    rexp_t e;
                    e = rq.pop_front();
                    rd_pops++;
                    chk(ce_v[e.rs] == ce_for(e.ra), "R1", "ref bank enables", ce_v[e.rs], ce_for(e.ra));
                    chk(ad_v[e.rs] == e.ra, "R6", "ref address", ad_v[e.rs], e.ra);
                    if (e.zero) begin
                        chk(ce_v[!e.rs] == '1, "R7", "outside search standby", ce_v[!e.rs], '1);
                    end else begin
                        chk(ce_v[!e.rs] == ce_for(e.sa), "R1", "search bank enables", ce_v[!e.rs], ce_for(e.sa));
                        chk(ad_v[!e.rs] == e.sa, "R6", "search address", ad_v[!e.rs], e.sa);
                    end
                    prev_e = e;
                    prev_rd = 1'b1;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: one frame; mode 1 adds one-byte line-valid blips and uneven gaps
    task automatic send_frame(input int f, input int mode);
        int addr = 0;
        fv_in = 1'b1;
        lv_in = 1'b0;
        tick();
        tick();
        for (int row = 0; row < H; row++) begin
            for (int k = 0; k < 2 * W; k++) begin
                lv_in = 1'b1;
                if (k % 2 == 1) begin
                    pix_in = 8'((f * 37 + row * 11 + (k / 2) * 5 + 3) & 255);
                    wq.push_back('{st: 1'(f % 2), a: AW'(addr), d: pix_in});
                    addr++;
                end else begin
                    pix_in = 8'(8'h80 ^ k);
                end
                tick();
            end
            lv_in = 1'b0;
            pix_in = 8'hEE;
            tick();
            if (mode == 1) begin
                lv_in = 1'b1;
                pix_in = 8'h5A;
                tick();
                lv_in = 1'b0;
                for (int g = 0; g < row % 3 + 1; g++) tick();
            end else begin
                tick();
            end
        end
    endtask

    task automatic push_reads(input int f);
        for (int by = 0; by < H / B; by++)
        for (int bx = 0; bx < W / B; bx++)
        for (int dy = 0; dy < NSP; dy++)
        for (int dx = 0; dx < NSP; dx++)
        for (int i = 0; i < B; i++)
        for (int j = 0; j < B; j++) begin
            rexp_t e;
            int rr, rc, sr, sc;
            rr = by * B + i; rc = bx * B + j;
            sr = rr + dy - R; sc = rc + dx - R;
            e.rs = 1'((f + 1) % 2);
            e.ra = AW'(rr * W + rc);
            e.zero = !(sr >= 0 && sr < H && sc >= 0 && sc < W);
            e.sa = e.zero ? '0 : AW'(sr * W + sc);
            e.last = (dy == NSP - 1) && (dx == NSP - 1) && (i == B - 1) && (j == B - 1);
            rq.push_back(e);
        end
    endtask

    task automatic end_frame_full(input int f);
        int s0;
        s0 = stb_cnt;
        rd_pops = 0;
        push_reads(f);
        fv_in = 1'b0;
        repeat (NRD + 4) tick();
        chk(rq.size() == 0, "R5", "reads left after walk", rq.size(), 0);
        chk(rd_pops == NRD, "R6", "read count", rd_pops, NRD);
        chk(stb_cnt - s0 == NBLK, "R9", "block strobes", stb_cnt - s0, NBLK);
        chk(wq.size() == 0, "R3", "writes left", wq.size(), 0);
    endtask

    task automatic end_frame_abort(input int f, input int k);
        rd_pops = 0;
        push_reads(f);
        fv_in = 1'b0;
        repeat (k) tick();
        fv_in = 1'b1;
        tick();
        tick();
        chk(rd_pops == k - 1, "R5", "reads before abort", rd_pops, k - 1);
        rq.delete();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        // R11 reset state
        chk(st0_ce_n == '1 && st1_ce_n == '1, "R11", "enables in reset", {st1_ce_n, st0_ce_n}, '1);
        chk(st0_we_n && st1_we_n, "R11", "write enables in reset", {st1_we_n, st0_we_n}, 3);
        chk(!rd_vld && !pix_stb && !fv_out, "R11", "strobes in reset", {rd_vld, pix_stb, fv_out}, 0);
        rst = 1'b0;
        repeat (3) tick();
        send_frame(0, 0);
        end_frame_full(0);
        send_frame(1, 1);
        end_frame_full(1);
        send_frame(2, 0);
        end_frame_abort(2, 40);
        send_frame(3, 1);
        end_frame_full(3);
        finish_run();
    end

endmodule